// File: doc/BRIEF.md
# Covariance Matrix Recursion Engine

This block fills the upper triangle of a square covariance-style matrix from a buffered array of signed samples. It does not take a full dot product for each entry. Each entry at row `i`, column `k` is built from the entry one step up and one step left on the same diagonal. The engine adds one sample product to that entry and subtracts a second sample product taken at a shifted offset. A host first fills the sample memory and preloads row 0 of the matrix memory. It then pulses `start` with a size and two base offsets, waits for `done`, and reads results through a read port.

Inside, a small controller walks the rows and columns. Two address generators turn the current row and column indices into sample addresses. A single signed multiplier is used twice for each element, and a 40-bit accumulator performs the add and the subtract. The result memory is a 16x16 array of 40-bit entries, addressed as `{row, col}`.

Top module: `cov_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0.
- R2: A `start` seen while `busy` is 0 captures `len_in`, `np_base` and `na_base`, and `busy` is 1 from the next cycle. Changes on those inputs while busy have no effect on the results.
- R3: For 1 <= i <= k <= len, entry (i,k) = entry (i-1,k-1) + s[A]*s[B] - s[C]*s[D]. The samples are 16-bit signed, the products are 32-bit signed and sign-extended, and the sum wraps modulo 2^40.
- R4: Sample addresses are computed modulo 64. A = np_base-i, B = np_base-k, C = na_base-1-i and D = na_base-1-k.
- R5: The engine writes only entries with 1 <= i <= k <= len. Row 0, the lower triangle and the entries past `len` keep their values.
- R6: Each element takes exactly 4 cycles. With n = len*(len+1)/2, `done` is 1 for exactly one cycle, 4n+1 cycles after the start edge. `busy` falls together with `done`.
- R7: A `start` pulse while `busy` is 1 is ignored, and no second run follows.
- R8: Host writes to the sample memory and to the matrix memory are ignored while `busy` is 1.
- R9: With `len_in` = 0, no entry is written and `done` pulses in the first cycle after the start edge.
- R10: Matrix entry (row, col) sits at address row*16+col. The host write port and the read port use that address, and the read is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| len_in | input | 4 | Matrix size (last row and column index) |
| np_base | input | 6 | Base offset of the added product |
| na_base | input | 6 | Base offset of the subtracted product |
| smp_we | input | 1 | Sample memory write enable |
| smp_addr | input | 6 | Sample memory write address |
| smp_data | input | 16 | Sample write data (signed) |
| phi_we | input | 1 | Matrix memory host write enable |
| phi_waddr | input | 8 | Matrix host write address {row,col} |
| phi_wdata | input | 40 | Matrix host write data |
| phi_raddr | input | 8 | Matrix read address {row,col} |
| phi_rdata | output | 40 | Matrix read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench targets several specific failure modes, each with a distinct symptom:
- Base offsets near zero make the sample addresses wrap. A design that clamps instead of wrapping reads the wrong samples, and the results differ.
- Row 0 is preloaded close to the positive limit, so the sum must wrap. A saturating design or a narrower accumulator shows wrong entries.
- A sentinel pattern across the whole matrix memory exposes stray writes to row 0, to the lower triangle or past `len`.
- A start pulse, new inputs, a sample write and a matrix write are all injected mid-run. A design that restarts or accepts them shows a different cycle count or different results.
- A size of zero checks that the engine finishes at once and does not write a single element.

// File: rtl/cov_pkg.sv
package cov_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRED  = 3'd1,
    ST_MULA  = 3'd2,
    ST_MULS  = 3'd3,
    ST_WRITE = 3'd4,
    ST_FIN   = 3'd5
  } cov_state_t;
endpackage

// File: rtl/cov_agu.sv
module cov_agu #(
  parameter int IW  = 4,
  parameter int SAW = 6
) (
  input  logic [SAW-1:0] base,
  input  logic [IW-1:0]  idx,
  input  logic           minus_one,
  output logic [SAW-1:0] addr
);
  localparam int EXT = (SAW > IW) ? SAW - IW : 0;
  logic [SAW-1:0] idx_ext;
  always_comb begin
    idx_ext = {{EXT{1'b0}}, idx};
    addr    = base - idx_ext - {{(SAW-1){1'b0}}, minus_one};
  end
endmodule

// File: rtl/cov_ctrl.sv
module cov_ctrl
  import cov_pkg::*;
#(
  parameter int IW  = 4,
  parameter int SAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [IW-1:0]  len_in,
  input  logic [SAW-1:0] np_in,
  input  logic [SAW-1:0] na_in,
  output logic [IW-1:0]  row,
  output logic [IW-1:0]  col,
  output logic [IW-1:0]  len_q,
  output logic [SAW-1:0] np_q,
  output logic [SAW-1:0] na_q,
  output logic           pred_ld,
  output logic           acc_add,
  output logic           acc_sub,
  output logic           eng_we,
  output logic           busy,
  output logic           done
);
  cov_state_t     state, state_n;
  logic [IW-1:0]  row_n, col_n;
  logic           cfg_en;

  always_comb begin
    state_n = state;
    row_n   = row;
    col_n   = col;
    cfg_en  = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        cfg_en  = 1'b1;
        row_n   = IW'(1);
        col_n   = IW'(1);
        state_n = (len_in == '0) ? ST_FIN : ST_PRED;
      end
      ST_PRED: state_n = ST_MULA;
      ST_MULA: state_n = ST_MULS;
      ST_MULS: state_n = ST_WRITE;
      ST_WRITE: begin
        state_n = ST_PRED;
        if (col == len_q) begin
          if (row == len_q) begin
            state_n = ST_FIN;
          end else begin
            row_n = row + IW'(1);
            col_n = row + IW'(1);
          end
        end else begin
          col_n = col + IW'(1);
        end
      end
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      row   <= '0;
      col   <= '0;
      len_q <= '0;
      np_q  <= '0;
      na_q  <= '0;
    end else begin
      state <= state_n;
      row   <= row_n;
      col   <= col_n;
      if (cfg_en) begin
        len_q <= len_in;
        np_q  <= np_in;
        na_q  <= na_in;
      end
    end
  end

  always_comb begin
    pred_ld = (state == ST_PRED);
    acc_add = (state == ST_MULA);
    acc_sub = (state == ST_MULS);
    eng_we  = (state == ST_WRITE);
    busy    = (state != ST_IDLE);
    done    = (state == ST_FIN);
  end
endmodule

// File: rtl/cov_dp.sv
module cov_dp #(
  parameter int IW  = 4,
  parameter int SAW = 6,
  parameter int SW  = 16,
  parameter int AW  = 40
) (
  input  logic            clk,
  input  logic            smp_we,
  input  logic [SAW-1:0]  smp_addr,
  input  logic [SW-1:0]   smp_data,
  input  logic [SAW-1:0]  rd_a,
  input  logic [SAW-1:0]  rd_b,
  input  logic            pred_ld,
  input  logic            acc_add,
  input  logic            acc_sub,
  input  logic            eng_we,
  input  logic [IW-1:0]   row,
  input  logic [IW-1:0]   col,
  input  logic            host_we,
  input  logic [2*IW-1:0] host_waddr,
  input  logic [AW-1:0]   host_wdata,
  input  logic [2*IW-1:0] raddr,
  output logic [AW-1:0]   rdata
);
  localparam int SDEPTH = 1 << SAW;
  localparam int PDEPTH = 1 << (2*IW);
  localparam int PW     = 2*SW;

  logic [SW-1:0]         smem [SDEPTH];
  logic [AW-1:0]         pmem [PDEPTH];
  logic [AW-1:0]         acc;
  logic signed [PW-1:0]  prod;
  logic [AW-1:0]         prod_ext;
  logic [2*IW-1:0]       pred_addr, wr_addr;

  always_ff @(posedge clk) begin
    if (smp_we) smem[smp_addr] <= smp_data;
  end

  always_comb begin
    prod      = $signed(smem[rd_a]) * $signed(smem[rd_b]);
    prod_ext  = {{(AW-PW){prod[PW-1]}}, prod};
    pred_addr = {row - IW'(1), col - IW'(1)};
    wr_addr   = {row, col};
    rdata     = pmem[raddr];
  end

  always_ff @(posedge clk) begin
    if (pred_ld)      acc <= pmem[pred_addr];
    else if (acc_add) acc <= acc + prod_ext;
    else if (acc_sub) acc <= acc - prod_ext;
  end

  always_ff @(posedge clk) begin
    if (eng_we)       pmem[wr_addr]    <= acc;
    else if (host_we) pmem[host_waddr] <= host_wdata;
  end
endmodule

// File: rtl/cov_engine.sv
module cov_engine #(
  parameter int IW  = 4,
  parameter int SAW = 6,
  parameter int SW  = 16,
  parameter int AW  = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IW-1:0]   len_in,
  input  logic [SAW-1:0]  np_base,
  input  logic [SAW-1:0]  na_base,
  input  logic            smp_we,
  input  logic [SAW-1:0]  smp_addr,
  input  logic [SW-1:0]   smp_data,
  input  logic            phi_we,
  input  logic [2*IW-1:0] phi_waddr,
  input  logic [AW-1:0]   phi_wdata,
  input  logic [2*IW-1:0] phi_raddr,
  output logic [AW-1:0]   phi_rdata,
  output logic            busy,
  output logic            done
);
  logic [IW-1:0]  row, col, len_q;
  logic [SAW-1:0] np_q, na_q, base_sel, rd_a, rd_b;
  logic           pred_ld, acc_add, acc_sub, eng_we;
  logic           smp_we_g, phi_we_g;

  cov_ctrl #(.IW(IW), .SAW(SAW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len_in(len_in),
    .np_in(np_base), .na_in(na_base), .row(row), .col(col),
    .len_q(len_q), .np_q(np_q), .na_q(na_q), .pred_ld(pred_ld),
    .acc_add(acc_add), .acc_sub(acc_sub), .eng_we(eng_we),
    .busy(busy), .done(done)
  );

  always_comb begin
    base_sel = acc_sub ? na_q : np_q;
    smp_we_g = smp_we & ~busy;
    phi_we_g = phi_we & ~busy;
  end

  cov_agu #(.IW(IW), .SAW(SAW)) u_agu_row (
    .base(base_sel), .idx(row), .minus_one(acc_sub), .addr(rd_a)
  );
  cov_agu #(.IW(IW), .SAW(SAW)) u_agu_col (
    .base(base_sel), .idx(col), .minus_one(acc_sub), .addr(rd_b)
  );

  cov_dp #(.IW(IW), .SAW(SAW), .SW(SW), .AW(AW)) u_dp (
    .clk(clk), .smp_we(smp_we_g), .smp_addr(smp_addr), .smp_data(smp_data),
    .rd_a(rd_a), .rd_b(rd_b), .pred_ld(pred_ld), .acc_add(acc_add),
    .acc_sub(acc_sub), .eng_we(eng_we), .row(row), .col(col),
    .host_we(phi_we_g), .host_waddr(phi_waddr), .host_wdata(phi_wdata),
    .raddr(phi_raddr), .rdata(phi_rdata)
  );
endmodule

// File: rtl/cov_engine_chk.sv
module cov_engine_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [IW-1:0] len_in,
  input logic          busy,
  input logic          done,
  input logic          eng_we,
  input logic [IW-1:0] row,
  input logic [IW-1:0] col,
  input logic [IW-1:0] len_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> (!busy && !done));

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_upper_tri_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> (row != '0 && col >= row && col <= len_q));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_empty_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len_in == '0) |=> done);
endmodule

bind cov_engine cov_engine_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .len_in(len_in), .busy(busy),
  .done(done), .eng_we(eng_we), .row(row), .col(col), .len_q(len_q)
);

// File: tb/cov_engine_test.sv
module cov_engine_test;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  len_in;
  logic [5:0]  np_base, na_base;
  logic        smp_we;
  logic [5:0]  smp_addr;
  logic [15:0] smp_data;
  logic        phi_we;
  logic [7:0]  phi_waddr, phi_raddr;
  logic [39:0] phi_wdata, phi_rdata;
  logic        busy, done;

  int total = 0;
  int bad   = 0;

  logic [15:0] sm [64];
  logic [39:0] pm [256];

  // {len, np, na, seed}
  localparam logic [23:0] VEC [5] = '{
    {4'd1,  6'd10, 6'd20, 8'd3},
    {4'd5,  6'd2,  6'd0,  8'd17},
    {4'd15, 6'd63, 6'd40, 8'd91},
    {4'd8,  6'd30, 6'd30, 8'd200},
    {4'd15, 6'd5,  6'd12, 8'd44}
  };

  cov_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_in(len_in),
    .np_base(np_base), .na_base(na_base), .smp_we(smp_we),
    .smp_addr(smp_addr), .smp_data(smp_data), .phi_we(phi_we),
    .phi_waddr(phi_waddr), .phi_wdata(phi_wdata), .phi_raddr(phi_raddr),
    .phi_rdata(phi_rdata), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load_samples(input int seed);
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      smp_we = 1'b1; smp_addr = 6'(a);
      smp_data = 16'((a * (seed * 73 + 19)) ^ (seed * 977));
      sm[a] = smp_data;
    end
    @(negedge clk); smp_we = 1'b0;
  endtask

  task automatic set_sample(input int a, input logic [15:0] v);
    @(negedge clk);
    smp_we = 1'b1; smp_addr = 6'(a); smp_data = v; sm[a] = v;
    @(negedge clk); smp_we = 1'b0;
  endtask

  task automatic preload_phi(input int seed, input bit high);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      phi_we = 1'b1; phi_waddr = 8'(a);
      if (high) phi_wdata = 40'h7F_FFFF_FFF0 - 40'(a);
      else phi_wdata = 40'(longint'(a) * 64'h1_0003_0007 + longint'(seed) * 12345);
      pm[a] = phi_wdata;
    end
    @(negedge clk); phi_we = 1'b0;
  endtask

  task automatic model(input int ln, input int np, input int na);
    logic [39:0] p1, p2;
    for (int i = 1; i <= ln; i++)
      for (int k = i; k <= ln; k++) begin
        p1 = 40'(longint'($signed(sm[(np - i) & 63])) * longint'($signed(sm[(np - k) & 63])));
        p2 = 40'(longint'($signed(sm[(na - 1 - i) & 63])) * longint'($signed(sm[(na - 1 - k) & 63])));
        pm[i*16 + k] = pm[(i-1)*16 + k - 1] + p1 - p2;
      end
  endtask

  task automatic run_job(input int ln, input int np, input int na, input bit inject);
    int cyc;
    int expc;
    expc = 4 * (ln * (ln + 1) / 2) + 1;
    @(negedge clk);
    start = 1'b1; len_in = 4'(ln); np_base = 6'(np); na_base = 6'(na);
    @(posedge clk); @(negedge clk);
    start = 1'b0; cyc = 1;
    chk(busy === 1'b1, "R2", "busy after start", 40'(busy), 40'd1);
    while (!done && cyc < 2000) begin
      if (inject && cyc == 3) begin
        start = 1'b1; len_in = 4'd15; np_base = 6'(np + 5); na_base = 6'(na + 7);
        smp_we = 1'b1; smp_addr = 6'((np - 1) & 63); smp_data = 16'h1234;
        phi_we = 1'b1; phi_waddr = 8'h55; phi_wdata = '1;
      end else begin
        start = 1'b0; smp_we = 1'b0; phi_we = 1'b0;
      end
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    start = 1'b0; smp_we = 1'b0; phi_we = 1'b0;
    chk(cyc == expc, inject ? "R7" : "R6", "done cycle", 40'(cyc), 40'(expc));
    @(posedge clk); @(negedge clk);
    chk(!done && !busy, "R6", "done one cycle then idle", {38'd0, done, busy}, 40'd0);
    // a start pulse ignored mid-run must not launch a second run
    @(posedge clk); @(negedge clk);
    chk(!busy, "R7", "no second run", 40'(busy), 40'd0);
  endtask

  task automatic compare_all(input int ln);
    for (int a = 0; a < 256; a++) begin
      int r;
      int c;
      r = a / 16; c = a % 16;
      phi_raddr = 8'(a);
      #1;
      if (r >= 1 && c >= r && c <= ln)
        chk(phi_rdata === pm[a], "R3", $sformatf("entry %0d,%0d", r, c), phi_rdata, pm[a]);
      else
        chk(phi_rdata === pm[a], "R5", $sformatf("untouched %0d,%0d", r, c), phi_rdata, pm[a]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R6 watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; len_in = '0; np_base = '0; na_base = '0;
    smp_we = 1'b0; smp_addr = '0; smp_data = '0;
    phi_we = 1'b0; phi_waddr = '0; phi_wdata = '0; phi_raddr = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1", "reset outputs", {38'd0, busy, done}, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1", "after release", {38'd0, busy, done}, 40'd0);

    // table of runs: R3 R4 R5 R6 R10
    for (int v = 0; v < 5; v++) begin
      int ln; int np; int na; int sd;
      ln = int'(VEC[v][23:20]); np = int'(VEC[v][19:14]);
      na = int'(VEC[v][13:8]);  sd = int'(VEC[v][7:0]);
      load_samples(sd);
      preload_phi(sd, 1'b0);
      model(ln, np, na);
      run_job(ln, np, na, 1'b0);
      compare_all(ln);
    end

    // R9: size zero writes nothing
    preload_phi(7, 1'b0);
    run_job(0, 9, 9, 1'b0);
    compare_all(0);

    // R3 wraparound: added product 2^30, subtracted product 0, row 0 near max
    for (int a = 0; a < 64; a++) set_sample(a, (a < 32) ? 16'h8000 : 16'h0000);
    preload_phi(0, 1'b1);
    model(15, 20, 60);
    run_job(15, 20, 60, 1'b0);
    compare_all(15);
    phi_raddr = 8'h11; #1;
    chk(phi_rdata[39] === 1'b1, "R3", "wrap sign of 1,1", 40'(phi_rdata[39]), 40'd1);

    // R7 R8 R2: start, new inputs and host writes injected mid-run
    load_samples(123);
    preload_phi(55, 1'b0);
    model(3, 12, 25);
    run_job(3, 12, 25, 1'b1);
    compare_all(3);
    phi_raddr = 8'h55; #1;
    chk(phi_rdata === pm[8'h55], "R8", "host matrix write while busy", phi_rdata, pm[8'h55]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule